// File: doc/BRIEF.md
# Undervoltage Reset Pulse Generator

This block drives the active-low reset line of a host microcontroller from a regulator-good flag, which arrives already synchronized. The line stays low from power-up until the regulator has been good for a full hold interval. A real supply failure must persist through a short debounce interval before the line goes low again. The line then stays low until a new, complete hold interval has passed with the supply good. Each failure during the hold interval restarts that interval from zero.

When the mode controller shuts the regulator down on purpose for sleep, the collapsing supply does not pulse the reset line. When sleep ends, the regulator restarts from off. The block then treats this like a power-up: reset goes low and a full hold interval is required before release. A second output tells the mode controller that reset is active, so that it can block mode changes during that time.

Both intervals are parameters counted in ticks of an external time base. One tick is a single-cycle strobe on `tick`. A tick counts only in the cycle in which it is high.

Top module: `uv_reset_pulse`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first hold interval has expired, `host_rst_n` is 0 and `rst_busy` is 1.
- R2: While reset is active, `host_rst_n` rises at the clock edge that samples the HOLD_TICKS-th tick counted with `supply_ok` high. No number of clock cycles without ticks releases it.
- R3: A cycle with `supply_ok` low during the hold interval discards the ticks counted so far. After `supply_ok` returns high, a full HOLD_TICKS ticks are needed again.
- R4: With reset released and `sleep_req` low, `supply_ok` going low and staying low through DEB_TICKS ticks drives `host_rst_n` low at the edge that samples the DEB_TICKS-th tick. A tick sampled in the same cycle in which `supply_ok` first reads low is not counted.
- R5: A low pulse on `supply_ok` that ends before DEB_TICKS ticks have been counted leaves `host_rst_n` high throughout.
- R6: With reset released, `sleep_req` high, whether it arrives before the supply drop, in the same cycle, or during debounce, keeps `host_rst_n` high however long `supply_ok` stays low.
- R7: When `sleep_req` falls after a sleep entry, `host_rst_n` goes low at the next edge and is released only after a full HOLD_TICKS ticks with `supply_ok` high.
- R8: `rst_busy` is at every edge the logical inverse of `host_rst_n`.
- R9: While reset is active, `sleep_req` has no effect. The hold interval completes as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the block |
| supply_ok | input | 1 | Synchronized regulator-good flag, 1 = output in regulation |
| sleep_req | input | 1 | 1 = mode controller has ordered sleep (regulator off on purpose) |
| tick | input | 1 | Single-cycle time-base strobe |
| host_rst_n | output | 1 | Active-low reset to the host microcontroller |
| rst_busy | output | 1 | 1 = reset active, mode changes must be held off |

## Verification
Every result is due at the single rising edge that samples the deciding input: the last needed tick for a release or an assertion, or the change of `supply_ok` or `sleep_req` for the other transitions. No output lags that edge by more than one register. The bench drives inputs just after a falling edge and checks the outputs at the following falling edge, exactly one rising edge later. With a small configuration, it sweeps every tick count up to each interval and every glitch length from zero to the debounce length. It compares each result with an expectation computed from the count, such as `g < DEB_TICKS`.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DBNC  = 2'd2,
    ST_SLEEP = 2'd3
  } uvr_state_e;
endpackage

// File: rtl/uvr_tick_counter.sv
module uvr_tick_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + CW'(1);
  end

  assign done = tick && (cnt_q == limit - CW'(1));

  // R3: the count never passes the active interval
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit);
endmodule

// File: rtl/uvr_state_ctl.sv
module uvr_state_ctl
  import uvr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic sleep_req,
  input  logic tick,
  input  logic done,
  output logic sel_dbnc,
  output logic cnt_clear,
  output logic rst_active
);
  uvr_state_e state_q, nxt;
  logic       rst_q;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_HOLD:  if (supply_ok && done) nxt = ST_RUN;
      ST_RUN: begin
        if (sleep_req)       nxt = ST_SLEEP;
        else if (!supply_ok) nxt = ST_DBNC;
      end
      ST_DBNC: begin
        if (sleep_req)      nxt = ST_SLEEP;
        else if (supply_ok) nxt = ST_RUN;
        else if (done)      nxt = ST_HOLD;
      end
      ST_SLEEP: if (!sleep_req) nxt = ST_HOLD;
      default:  nxt = ST_HOLD;
    endcase
  end

  assign cnt_clear = (nxt != state_q) || (state_q == ST_RUN) ||
                     (state_q == ST_SLEEP) ||
                     ((state_q == ST_HOLD) && !supply_ok);
  assign sel_dbnc  = (state_q == ST_DBNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      rst_q   <= 1'b1;
    end else begin
      state_q <= nxt;
      rst_q   <= (nxt == ST_HOLD);
    end
  end

  assign rst_active = rst_q;

  // R2: release only on a tick counted with the supply good
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> $past(supply_ok && tick));
  // R3: a failure during hold keeps the block in hold
  p_hold_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !supply_ok) |=> (state_q == ST_HOLD));
  // R4, R7: reset asserts only on a real failure or on sleep exit
  p_assert_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> ($past(!supply_ok) || ($past(state_q) == ST_SLEEP)));
  // R5: supply returning during debounce keeps reset released
  p_glitch_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DBNC && supply_ok && !sleep_req) |=> !rst_q);
  // R6: no reset while sleeping
  p_sleep_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) |-> !rst_q);
endmodule

// File: rtl/uv_reset_pulse.sv
module uv_reset_pulse #(
  parameter int HOLD_TICKS = 10000,
  parameter int DEB_TICKS  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic sleep_req,
  input  logic tick,
  output logic host_rst_n,
  output logic rst_busy
);
  localparam int MAXT = (HOLD_TICKS > DEB_TICKS) ? HOLD_TICKS : DEB_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic          sel_dbnc, cnt_clear, done, rst_active;
  logic [CW-1:0] limit;

  assign limit = sel_dbnc ? CW'(DEB_TICKS) : CW'(HOLD_TICKS);

  uvr_tick_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (cnt_clear),
    .tick  (tick),
    .limit (limit),
    .done  (done)
  );

  uvr_state_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .sleep_req  (sleep_req),
    .tick       (tick),
    .done       (done),
    .sel_dbnc   (sel_dbnc),
    .cnt_clear  (cnt_clear),
    .rst_active (rst_active)
  );

  assign host_rst_n = !rst_active;
  assign rst_busy   = rst_active;

  // R8: status and reset line always agree
  p_busy_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy == !host_rst_n);
endmodule

// File: tb/uv_reset_pulse_tb.sv
module uv_reset_pulse_tb;
  localparam int H = 4;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, supply_ok = 1'b0, sleep_req = 1'b0, tick = 1'b0;
  logic host_rst_n, rst_busy;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  always #4 clk = ~clk;

  uv_reset_pulse #(.HOLD_TICKS(H), .DEB_TICKS(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sleep_req(sleep_req),
    .tick(tick), .host_rst_n(host_rst_n), .rst_busy(rst_busy)
  );

  task automatic chk(input string tag, input logic exp_active);
    n_chk++;
    if (host_rst_n !== !exp_active) begin
      n_fail++;
      $display("FAIL %s host_rst_n act=%b exp=%b", tag, host_rst_n, !exp_active);
    end
    n_chk++;
    if (rst_busy !== exp_active) begin
      n_fail++;
      $display("FAIL %s rst_busy act=%b exp=%b", tag, rst_busy, exp_active);
    end
  endtask

  task automatic step(input logic t);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Release from hold with supply good (R2 path)
  task automatic recover();
    supply_ok = 1'b1;
    for (int k = 1; k <= H; k++) begin
      step(1'b1);
      chk("R2 recover", k < H);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R1 act=timeout exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1'b1);
    chk("R1 in reset", 1'b1);
    rst_n = 1'b1;
    step(1'b0);
    chk("R1 after reset", 1'b1);

    // R2: no ticks, no release even with supply good
    supply_ok = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1'b0);
      chk("R2 no ticks", 1'b1);
    end
    for (int k = 1; k <= H; k++) begin
      step(1'b1);
      chk("R2 hold sweep", k < H);
    end

    // R4: full debounce asserts reset
    supply_ok = 1'b0;
    step(1'b1);
    chk("R4 drop edge", 1'b0);
    for (int k = 1; k <= D; k++) begin
      step(1'b1);
      chk("R4 debounce", k >= D);
    end

    // R3: failure during hold restarts the count
    supply_ok = 1'b1;
    for (int k = 1; k < H; k++) step(1'b1);
    chk("R3 partial hold", 1'b1);
    supply_ok = 1'b0;
    step(1'b1);
    chk("R3 fail in hold", 1'b1);
    supply_ok = 1'b1;
    for (int k = 1; k < H; k++) begin
      step(1'b1);
      chk("R3 restarted", 1'b1);
    end
    step(1'b1);
    chk("R3 full hold", 1'b0);

    // R5 / R4: glitch length sweep
    for (int g = 0; g <= D; g++) begin
      supply_ok = 1'b0;
      step(1'b0);
      for (int k = 0; k < g; k++) step(1'b1);
      supply_ok = 1'b1;
      step(1'b0);
      chk(g < D ? "R5 short glitch" : "R4 long glitch", !(g < D));
      if (g >= D) recover();
    end

    // R6: sleep and supply drop in the same cycle
    sleep_req = 1'b1;
    supply_ok = 1'b0;
    step(1'b0);
    chk("R6 sleep entry", 1'b0);
    for (int k = 0; k < D + 2; k++) begin
      step(1'b1);
      chk("R6 sleep quiet", 1'b0);
    end

    // R7: sleep exit asserts reset, full hold needed
    sleep_req = 1'b0;
    step(1'b1);
    chk("R7 sleep exit", 1'b1);
    recover();

    // R6: sleep arriving during debounce
    supply_ok = 1'b0;
    step(1'b0);
    step(1'b1);
    sleep_req = 1'b1;
    step(1'b0);
    chk("R6 sleep in debounce", 1'b0);
    for (int k = 0; k < D; k++) begin
      step(1'b1);
      chk("R6 sleep in debounce hold", 1'b0);
    end
    sleep_req = 1'b0;
    step(1'b0);
    chk("R7 sleep exit 2", 1'b1);

    // R9: sleep ignored while reset active
    sleep_req = 1'b1;
    supply_ok = 1'b1;
    for (int k = 1; k <= H; k++) begin
      step(1'b1);
      chk("R9 sleep in hold", k < H);
    end
    step(1'b0);
    chk("R6 sleep after release", 1'b0);
    sleep_req = 1'b0;
    step(1'b0);
    chk("R7 sleep exit 3", 1'b1);
    recover();
    chk("R8 final", 1'b0);

    finished = 1;
    summary();
    $finish;
  end
endmodule